// File: doc/BRIEF.md
# Iterative Multiply and Divide Unit

This unit runs the multiply and divide operations of a 32-bit core's execute stage over several cycles. The core presents two operands, an operation code and a one-cycle start request while the unit is idle. The unit accepts the request, works through one operand bit per cycle and then raises `done_o` for one cycle. In that cycle it also presents a 32-bit result and a write-enable for the destination register.

Multiplication uses a shift-add datapath on operand magnitudes, and the sign is applied after the last step. The unit can return the low product word or the high product word, and the high word comes in three signedness forms. Division uses a restoring datapath on magnitudes, and the quotient is truncated toward zero. A zero divisor completes early with the write-enable held low, so the destination register keeps its old value.

Top module: `muldiv_unit`

## Requirements
- R1: With op code 0, the result is bits 31:0 of the product of A and B.
- R2: With op code 3, the result is bits 63:32 of the product, with both A and B taken as unsigned.
- R3: With op code 2, the result is bits 63:32 of the product, with A taken as signed (two's complement) and B taken as unsigned.
- R4: With op code 1, the result is bits 63:32 of the product, with both A and B taken as signed.
- R5: With op code 5 and a nonzero B, the result is the unsigned quotient A/B.
- R6: With op code 4 and a nonzero B, the result is the signed quotient A/B truncated toward zero. 0x80000000 divided by 0xFFFFFFFF returns 0x80000000.
- R7: With op code 4 or 5 and B equal to zero, `done_o` rises in the cycle after the accepting edge, `wr_en_o` stays low and `result_o` is zero.
- R8: For every other accepted operation, `done_o` is high in the cycle that follows the 32nd clock edge after the accepting edge. That is 33 cycles counting the start cycle. `busy_o` is high from the accepting edge until the done cycle, inclusive.
- R9: A start request is ignored while `busy_o` is high, including in the done cycle. It produces no further done pulse and does not alter the result in progress.
- R10: `done_o` lasts exactly one cycle. `wr_en_o` is high only together with `done_o`. `result_o` is zero whenever `wr_en_o` is low.
- R11: After reset, `busy_o`, `done_o` and `wr_en_o` are low and `result_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, sampled when idle |
| op_i | input | 3 | Operation code (see R1 to R7) |
| a_i | input | 32 | Operand A (multiplicand or dividend) |
| b_i | input | 32 | Operand B (multiplier or divisor) |
| busy_o | output | 1 | Operation accepted and not yet retired |
| done_o | output | 1 | One-cycle completion pulse |
| wr_en_o | output | 1 | Destination write-enable, valid with done |
| result_o | output | 32 | Result word, valid when wr_en_o is high |

## Verification
The functions that can meet in one cycle are the completion of an operation and a new start request. While `done_o` is high the unit still counts as busy, so a request arriving then must be dropped rather than started. The bench provokes this by raising start exactly in the cycle it sees `done_o`, and again with a different op code partway through a run. It judges the outcome by checking that the retired result matches the original operands and that no second done pulse appears in the following 40 cycles. Signed extremes, zero divisors and random operands are compared against products and quotients that the bench computes with 64-bit integer arithmetic.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

  typedef enum logic [2:0] {
    OP_MUL    = 3'd0,
    OP_MULHSS = 3'd1,
    OP_MULHSU = 3'd2,
    OP_MULHUU = 3'd3,
    OP_DIVS   = 3'd4,
    OP_DIVU   = 3'd5
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } seq_state_e;

  function automatic logic op_is_div(input logic [2:0] op);
    return (op == OP_DIVS) || (op == OP_DIVU);
  endfunction

  function automatic logic op_a_signed(input logic [2:0] op);
    return (op == OP_MULHSS) || (op == OP_MULHSU) || (op == OP_DIVS);
  endfunction

  function automatic logic op_b_signed(input logic [2:0] op);
    return (op == OP_MULHSS) || (op == OP_DIVS);
  endfunction

  function automatic logic op_is_high(input logic [2:0] op);
    return (op == OP_MULHSS) || (op == OP_MULHSU) || (op == OP_MULHUU);
  endfunction

endpackage

// File: rtl/muldiv_seq.sv
module muldiv_seq
  import muldiv_pkg::*;
#(
  parameter int STEPS = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic accept_i,
  input  logic zero_div_i,
  output logic step_o,
  output logic fin_o,
  output logic busy_o,
  output logic dz_o
);
  localparam int CW = (STEPS > 1) ? $clog2(STEPS) : 1;
  localparam logic [CW-1:0] LAST = CW'(STEPS - 1);

  seq_state_e state_q;
  logic [CW-1:0] cnt_q;
  logic dz_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      dz_q    <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (accept_i) begin
            cnt_q   <= '0;
            dz_q    <= zero_div_i;
            state_q <= zero_div_i ? ST_FIN : ST_RUN;
          end
        end
        ST_RUN: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == LAST) state_q <= ST_FIN;
        end
        ST_FIN: begin
          dz_q    <= 1'b0;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign step_o = (state_q == ST_RUN);
  assign fin_o  = (state_q == ST_FIN);
  assign busy_o = (state_q != ST_IDLE);
  assign dz_o   = dz_q;
endmodule

// File: rtl/muldiv_mul_core.sv
module muldiv_mul_core #(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load_i,
  input  logic           step_i,
  input  logic [W-1:0]   mcand_i,
  input  logic [W-1:0]   mplier_i,
  output logic [2*W-1:0] prod_o
);
  logic [W-1:0]   mcand_q;
  logic [2*W-1:0] prod_q;
  logic [W:0]     partial_w;

  // one shift-add step: add multiplicand to upper half when the LSB is set
  assign partial_w = {1'b0, prod_q[2*W-1:W]} + (prod_q[0] ? {1'b0, mcand_q} : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcand_q <= '0;
      prod_q  <= '0;
    end else if (load_i) begin
      mcand_q <= mcand_i;
      prod_q  <= {{W{1'b0}}, mplier_i};
    end else if (step_i) begin
      prod_q <= {partial_w, prod_q[W-1:1]};
    end
  end

  assign prod_o = prod_q;
endmodule

// File: rtl/muldiv_div_core.sv
module muldiv_div_core #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic         step_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic [W-1:0] quot_o
);
  logic [W-1:0] rem_q;
  logic [W-1:0] quo_q;
  logic [W-1:0] dvs_q;
  logic [W:0]   trial_w;
  logic [W:0]   diff_w;
  logic         fits_w;

  // restoring step: shift in next dividend bit, subtract if it fits
  assign trial_w = {rem_q, quo_q[W-1]};
  assign diff_w  = trial_w - {1'b0, dvs_q};
  assign fits_w  = !diff_w[W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      quo_q <= '0;
      dvs_q <= '0;
    end else if (load_i) begin
      rem_q <= '0;
      quo_q <= dividend_i;
      dvs_q <= divisor_i;
    end else if (step_i) begin
      rem_q <= fits_w ? diff_w[W-1:0] : trial_w[W-1:0];
      quo_q <= {quo_q[W-2:0], fits_w};
    end
  end

  assign quot_o = quo_q;
endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit
  import muldiv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic [2:0]   op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         busy_o,
  output logic         done_o,
  output logic         wr_en_o,
  output logic [W-1:0] result_o
);
  localparam int PW = 2 * W;

  function automatic logic [W-1:0] mag_of(input logic [W-1:0] v, input logic sgn);
    return (sgn && v[W-1]) ? ('0 - v) : v;
  endfunction

  function automatic logic [W-1:0] pick_result(input logic [2:0] op, input logic neg,
                                               input logic [PW-1:0] prod,
                                               input logic [W-1:0] quo);
    logic [PW-1:0] p;
    logic [W-1:0]  q;
    p = neg ? ('0 - prod) : prod;
    q = neg ? ('0 - quo) : quo;
    if (op_is_div(op))       return q;
    else if (op_is_high(op)) return p[PW-1:W];
    else                     return p[W-1:0];
  endfunction

  // named internal events for the checker
  logic accept_w;
  logic step_w;
  logic fin_w;
  logic dz_w;
  logic zero_div_w;

  logic [2:0]    op_q;
  logic          neg_q;
  logic [W-1:0]  a_mag_w;
  logic [W-1:0]  b_mag_w;
  logic [PW-1:0] prod_w;
  logic [W-1:0]  quot_w;
  logic          load_mul_w;
  logic          load_div_w;

  assign accept_w   = start_i && !busy_o;
  assign zero_div_w = op_is_div(op_i) && (b_i == '0);
  assign a_mag_w    = mag_of(a_i, op_a_signed(op_i));
  assign b_mag_w    = mag_of(b_i, op_b_signed(op_i));
  assign load_mul_w = accept_w && !op_is_div(op_i);
  assign load_div_w = accept_w && op_is_div(op_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q  <= OP_MUL;
      neg_q <= 1'b0;
    end else if (accept_w) begin
      op_q  <= op_i;
      neg_q <= (op_a_signed(op_i) && a_i[W-1]) ^ (op_b_signed(op_i) && b_i[W-1]);
    end
  end

  muldiv_seq #(.STEPS(W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept_i  (accept_w),
    .zero_div_i(zero_div_w),
    .step_o    (step_w),
    .fin_o     (fin_w),
    .busy_o    (busy_o),
    .dz_o      (dz_w)
  );

  muldiv_mul_core #(.W(W)) u_mul (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (load_mul_w),
    .step_i  (step_w),
    .mcand_i (a_mag_w),
    .mplier_i(b_mag_w),
    .prod_o  (prod_w)
  );

  muldiv_div_core #(.W(W)) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (load_div_w),
    .step_i    (step_w),
    .dividend_i(a_mag_w),
    .divisor_i (b_mag_w),
    .quot_o    (quot_w)
  );

  assign done_o   = fin_w;
  assign wr_en_o  = fin_w && !dz_w;
  assign result_o = wr_en_o ? pick_result(op_q, neg_q, prod_w, quot_w) : '0;
endmodule

// File: rtl/muldiv_unit_chk.sv
module muldiv_unit_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start_i,
  input logic [2:0]   op_i,
  input logic [W-1:0] b_i,
  input logic         busy_o,
  input logic         done_o,
  input logic         wr_en_o,
  input logic [W-1:0] result_o,
  input logic         accept_w,
  input logic         step_w
);
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R10
  write_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> done_o);

  // R10
  quiet_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_o |-> (result_o == '0));

  // R7
  zero_div_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_w && (op_i == 3'd4 || op_i == 3'd5) && b_i == '0) |=> (done_o && !wr_en_o));

  // R8
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_o) |=> busy_o);

  // R9
  done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && start_i) |=> !busy_o);

  // R8
  step_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_w |-> (busy_o && !done_o));
endmodule

bind muldiv_unit muldiv_unit_chk #(.W(W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start_i (start_i),
  .op_i    (op_i),
  .b_i     (b_i),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .wr_en_o (wr_en_o),
  .result_o(result_o),
  .accept_w(accept_w),
  .step_w  (step_w)
);

// File: tb/muldiv_unit_tb.sv
module muldiv_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [2:0]  op_i = 3'd0;
  logic [31:0] a_i = '0;
  logic [31:0] b_i = '0;
  logic        busy_o, done_o, wr_en_o;
  logic [31:0] result_o;

  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  muldiv_unit u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
    .a_i(a_i), .b_i(b_i), .busy_o(busy_o), .done_o(done_o),
    .wr_en_o(wr_en_o), .result_o(result_o)
  );

  task automatic check(input logic ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] expect_res(input logic [2:0] op, input logic [31:0] a,
                                             input logic [31:0] b);
    longint sa, sb, ua, ub;
    logic [63:0] p;
    sa = longint'($signed(a)); sb = longint'($signed(b));
    ua = longint'({32'd0, a});  ub = longint'({32'd0, b});
    case (op)
      3'd0: begin p = 64'(ua * ub); return p[31:0]; end
      3'd1: begin p = 64'(sa * sb); return p[63:32]; end
      3'd2: begin p = 64'(sa * ub); return p[63:32]; end
      3'd3: begin p = {32'd0, a} * {32'd0, b}; return p[63:32]; end
      3'd4: begin p = 64'(sa / sb); return p[31:0]; end
      default: return a / b;
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] op);
    case (op)
      3'd0: return "R1";
      3'd1: return "R4";
      3'd2: return "R3";
      3'd3: return "R2";
      3'd4: return "R6";
      default: return "R5";
    endcase
  endfunction

  // mode 0: plain; 1: start again mid-run; 2: start again in done cycle
  task automatic run_op(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                        input int mode);
    int lat;
    int extra;
    logic dz;
    dz = (op >= 3'd4) && (b == 32'd0);
    @(negedge clk);
    op_i = op; a_i = a; b_i = b; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    lat = 1;
    if (mode == 1 && !dz) begin
      op_i = 3'd3; a_i = ~a; b_i = 32'hFFFF_FFFF; start_i = 1'b1;
    end
    while (!done_o && lat < 40) begin
      @(negedge clk);
      lat++;
      if (lat > 3) start_i = 1'b0;
    end
    start_i = 1'b0;
    if (dz) begin
      check(lat == 1, "R7", 32'(lat), 32'd1);
      check(!wr_en_o && result_o == 32'd0, "R7", result_o, 32'd0);
    end else begin
      check(lat == 33, "R8", 32'(lat), 32'd33);
      check(wr_en_o && busy_o, "R8", {30'd0, wr_en_o, busy_o}, 32'd3);
      check(result_o == expect_res(op, a, b), tag_of(op), result_o, expect_res(op, a, b));
    end
    if (mode == 2) begin
      op_i = 3'd0; a_i = 32'd7; b_i = 32'd9; start_i = 1'b1;
    end
    @(negedge clk);
    start_i = 1'b0;
    check(!done_o && !wr_en_o, "R10", {30'd0, done_o, wr_en_o}, 32'd0);
    if (mode != 0) begin
      extra = 0;
      for (int i = 0; i < 40; i++) begin
        if (done_o || busy_o) extra++;
        @(negedge clk);
      end
      check(extra == 0, "R9", 32'(extra), 32'd0);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : stim
    logic [2:0] rop;
    logic [31:0] ra, rb;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R11 reset state
    check(!busy_o && !done_o && !wr_en_o && result_o == 32'd0, "R11", result_o, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy_o && !done_o, "R11", {30'd0, busy_o, done_o}, 32'd0);

    run_op(3'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0);   // R1
    run_op(3'd3, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0);   // R2
    run_op(3'd2, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0);   // R3
    run_op(3'd1, 32'h8000_0000, 32'h8000_0000, 0);   // R4
    run_op(3'd1, 32'hFFFF_FFFE, 32'h0000_0003, 0);   // R4
    run_op(3'd5, 32'hFFFF_FFFF, 32'h0000_0001, 0);   // R5
    run_op(3'd4, 32'h8000_0000, 32'hFFFF_FFFF, 0);   // R6 overflow corner
    run_op(3'd4, 32'hFFFF_FFF9, 32'h0000_0002, 0);   // R6 -7/2 = -3
    run_op(3'd4, 32'h0000_0007, 32'hFFFF_FFFE, 0);   // R6 7/-2 = -3
    run_op(3'd4, 32'h1234_5678, 32'h0000_0000, 0);   // R7
    run_op(3'd5, 32'h0000_0001, 32'h0000_0000, 0);   // R7
    run_op(3'd3, 32'hDEAD_BEEF, 32'h0BAD_F00D, 1);   // R9 start mid-run
    run_op(3'd5, 32'h8765_4321, 32'h0000_0013, 2);   // R9 start in done cycle
    run_op(3'd4, 32'h0000_0000, 32'h0000_0000, 2);   // R9 with R7

    for (int n = 0; n < 60; n++) begin
      rop = 3'($urandom_range(0, 5));
      ra = $urandom;
      rb = $urandom;
      if (($urandom & 32'd7) == 0) rb = 32'd0;
      else if (($urandom & 32'd3) == 0) rb = rb >> ($urandom & 32'd31);
      run_op(rop, ra, rb, 0);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule